// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block gathers twelve interrupt requests and tells the processor core which one to serve next and where its handler lives. Four of the requests are level inputs from neighbouring logic: two external-pin requests and two timer-overflow requests. The other eight come from an asynchronous eight-bit input port. Each port bit is synchronised, compared against a per-bit polarity, and latched into a sticky request flag that only software clears.

Every source has its own enable bit and its own priority bit. A global enable gates all of them. The controller presents a vector address, a valid strobe and the level of the winning request. The core acknowledges a presented request with `irq_ack`. It signals the end of a handler with `irq_ret`. A two-entry in-service record lets a high-level request interrupt a low-level handler, and blocks everything while a high-level handler runs. A separate wake output asserts whenever an enabled port flag is pending, so that a stopped core can be restarted.

Top module: `intc2l`

## Requirements
- R1: After reset all six registers read 0x00, `irq_valid` is 0 and `wake_req` is 0.
- R2: The registers decode at fixed byte addresses. 0xA8 is the core-enable register: bit 7 is the global enable, bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1. 0xE8 is the port-enable register. 0xB8 holds the core priorities, with bits 0..3 in the same order as 0xA8. 0xF8 holds the port priorities. 0xE9 is the port polarity register. 0xC0 holds the port request flags. Bit n-2 of each port register belongs to port source n, for n = 2..9. Unimplemented bits (6:4 of 0xA8, 7:4 of 0xB8) read 0.
- R3: A port input passes through two flip-flops before the polarity is applied. A polarity bit of 0 means active low and 1 means active high. The flag reads 1 after the third rising edge following an input change, and still reads 0 after the second.
- R4: A port flag stays set after its input goes inactive. A write to 0xC0 loads the flags, but an input that is still active keeps its flag set. Writing 1 sets a flag.
- R5: A source is requested only when both its enable bit and the global enable are 1. A pending source with either bit 0 leaves `irq_valid` low.
- R6: The vectors are: external 0 0x0003, timer 0 0x000B, external 1 0x0013, timer 1 0x001B, and port sources 2..9 0x003B + 8*(n-2), giving 0x003B to 0x0073.
- R7: Among requests of the same level the winner follows this fixed order, highest first: ext0, port5, timer0, port6, ext1, port2, port7, timer1, port3, port8, port4, port9.
- R8: A high-level request (priority bit 1) wins over any low-level one, and `irq_hi` reports the level presented.
- R9: `irq_ack` while `irq_valid` records the presented level as in service. While a low-level handler is in service, only high-level requests are presented. While a high-level handler is in service, nothing is presented. `irq_ret` removes the most recent entry.
- R10: A source whose request is still active after its handler returns is presented again straight away.
- R11: `wake_req` is 1 whenever a port flag and its port-enable bit are both 1. It does not depend on the global enable or on the in-service state.
- R12: The external and timer request inputs act as levels: the request is presented in the cycle the input is high and disappears when the input falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_wr | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Register address for read and write |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Register read data (combinational on `sfr_addr`) |
| ext_req | input | 2 | External request levels, bit 0 = ext0, bit 1 = ext1 |
| tmr_req | input | 2 | Timer overflow request levels, bit 0 = timer0, bit 1 = timer1 |
| port_pin | input | 8 | Asynchronous port inputs, bit k = port source k+2 |
| irq_ack | input | 1 | Core accepts the presented request |
| irq_ret | input | 1 | Core leaves the current handler |
| irq_valid | output | 1 | A request is presented |
| irq_hi | output | 1 | The presented request is high level |
| irq_vector | output | 16 | Handler address of the presented request |
| wake_req | output | 1 | An enabled port flag is pending |

## Verification
A corrupted in-service record appears at `irq_valid` in the very next cycle. A stuck high-level entry silences every request. A lost low-level entry lets a second low request through. Both are visible immediately after the acknowledge or return that caused them. A wrong tie-break or vector table shows as a wrong `irq_vector` as soon as two sources are pending together. Synchroniser depth errors move the flag by a cycle, which the edge-exact flag read catches. A flag that clears itself shows up when the flag register is read back after the input falls.

// File: rtl/intc2l_pkg.sv
package intc2l_pkg;
   localparam int NSRC  = 12;
   localparam int NPORT = 8;
   localparam int NCORE = 4;
   localparam int SRC_W = $clog2(NSRC);

   // Source id: 0 ext0, 1 tmr0, 2 ext1, 3 tmr1, 4..11 port sources 2..9
   // Fixed tie-break: rank 0 is the strongest
   function automatic int rank_src(input int r);
      case (r)
         0: return 0;
         1: return 7;
         2: return 1;
         3: return 8;
         4: return 2;
         5: return 4;
         6: return 9;
         7: return 3;
         8: return 5;
         9: return 10;
         10: return 6;
         default: return 11;
      endcase
   endfunction

   function automatic logic [15:0] vec_of(input logic [SRC_W-1:0] s);
      logic [15:0] slot;
      slot = (s < SRC_W'(NCORE)) ? 16'(s) : 16'(s) + 16'd3;
      return (slot << 3) + 16'd3;
   endfunction
endpackage

// File: rtl/intc2l_sync.sv
module intc2l_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] IDLE = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("intc2l_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("intc2l_sync: WIDTH must be positive");
   end

   logic [STAGES-1:0][WIDTH-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {STAGES{IDLE}};
      else        pipe <= {pipe[STAGES-2:0], din};
   end

   assign dout = pipe[STAGES-1];
endmodule

// File: rtl/intc2l_sfr.sv
module intc2l_sfr #(
   parameter int SYNC_STAGES = 2,
   parameter logic [7:0] A_CEN = 8'hA8,
   parameter logic [7:0] A_PEN = 8'hE8,
   parameter logic [7:0] A_CPR = 8'hB8,
   parameter logic [7:0] A_PPR = 8'hF8,
   parameter logic [7:0] A_POL = 8'hE9,
   parameter logic [7:0] A_FLG = 8'hC0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [7:0] addr,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   input  logic [7:0] port_pin,
   output logic       glb_en,
   output logic [3:0] core_en,
   output logic [7:0] port_en,
   output logic [3:0] core_pri,
   output logic [7:0] port_pri,
   output logic [7:0] port_flag
);
   logic [7:0] pol_q;
   logic [7:0] pin_s;
   logic [7:0] active;
   logic       w_cen, w_pen, w_cpr, w_ppr, w_pol, w_flg;

   intc2l_sync #(.WIDTH(8), .STAGES(SYNC_STAGES), .IDLE(8'hFF)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (port_pin),
      .dout (pin_s)
   );

   assign active = ~(pin_s ^ pol_q);

   assign w_cen = wr && (addr == A_CEN);
   assign w_pen = wr && (addr == A_PEN);
   assign w_cpr = wr && (addr == A_CPR);
   assign w_ppr = wr && (addr == A_PPR);
   assign w_pol = wr && (addr == A_POL);
   assign w_flg = wr && (addr == A_FLG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glb_en    <= 1'b0;
         core_en   <= '0;
         port_en   <= '0;
         core_pri  <= '0;
         port_pri  <= '0;
         pol_q     <= '0;
         port_flag <= '0;
      end else begin
         if (w_cen) begin
            glb_en  <= wdata[7];
            core_en <= wdata[3:0];
         end
         if (w_pen) port_en  <= wdata;
         if (w_cpr) core_pri <= wdata[3:0];
         if (w_ppr) port_pri <= wdata;
         if (w_pol) pol_q    <= wdata;
         port_flag <= (w_flg ? wdata : port_flag) | active;
      end
   end

   always_comb begin
      rdata = 8'h00;
      if      (addr == A_CEN) rdata = {glb_en, 3'b000, core_en};
      else if (addr == A_PEN) rdata = port_en;
      else if (addr == A_CPR) rdata = {4'b0000, core_pri};
      else if (addr == A_PPR) rdata = port_pri;
      else if (addr == A_POL) rdata = pol_q;
      else if (addr == A_FLG) rdata = port_flag;
   end

   // R4
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !w_flg |=> ((port_flag & $past(port_flag)) == $past(port_flag)));

   // R3
   flag_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active != 8'h00) |=> ((port_flag & $past(active)) == $past(active)));
endmodule

// File: rtl/intc2l_arb.sv
module intc2l_arb
   import intc2l_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSRC-1:0]  hi_req,
   input  logic [NSRC-1:0]  lo_req,
   input  logic             allow_hi,
   input  logic             allow_lo,
   output logic             valid,
   output logic             hi,
   output logic [SRC_W-1:0] src
);
   logic [NSRC-1:0] cand;
   logic [NSRC-1:0] grant;
   logic [NSRC:0]   seen;

   assign hi   = allow_hi && (|hi_req);
   assign cand = hi ? hi_req : (allow_lo ? lo_req : '0);

   assign seen[0] = 1'b0;
   for (genvar r = 0; r < NSRC; r++) begin : g_rank
      localparam int S = rank_src(r);
      assign grant[S]  = cand[S] & ~seen[r];
      assign seen[r+1] = seen[r] | cand[S];
   end

   assign valid = seen[NSRC];

   always_comb begin
      src = '0;
      for (int i = 0; i < NSRC; i++) begin
         if (grant[i]) src = SRC_W'(i);
      end
   end

   // R7
   one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   // R8
   hi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !hi) |-> ((hi_req == '0) || !allow_hi));
endmodule

// File: rtl/intc2l_nest.sv
module intc2l_nest (
   input  logic clk,
   input  logic rst_n,
   input  logic push,
   input  logic push_hi,
   input  logic pop,
   output logic svc_hi,
   output logic svc_lo
);
   logic hi_n, lo_n;

   always_comb begin
      hi_n = svc_hi;
      lo_n = svc_lo;
      if (pop) begin
         if (svc_hi) hi_n = 1'b0;
         else        lo_n = 1'b0;
      end
      if (push) begin
         if (push_hi) hi_n = 1'b1;
         else         lo_n = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         svc_hi <= 1'b0;
         svc_lo <= 1'b0;
      end else begin
         svc_hi <= hi_n;
         svc_lo <= lo_n;
      end
   end

   // R9
   pop_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && svc_hi) |=> (!svc_hi && (svc_lo == $past(svc_lo))));
endmodule

// File: rtl/intc2l.sv
module intc2l
   import intc2l_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int VEC_W = 16,
   parameter logic [7:0] A_CEN = 8'hA8,
   parameter logic [7:0] A_PEN = 8'hE8,
   parameter logic [7:0] A_CPR = 8'hB8,
   parameter logic [7:0] A_PPR = 8'hF8,
   parameter logic [7:0] A_POL = 8'hE9,
   parameter logic [7:0] A_FLG = 8'hC0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sfr_wr,
   input  logic [7:0]       sfr_addr,
   input  logic [7:0]       sfr_wdata,
   output logic [7:0]       sfr_rdata,
   input  logic [1:0]       ext_req,
   input  logic [1:0]       tmr_req,
   input  logic [7:0]       port_pin,
   input  logic             irq_ack,
   input  logic             irq_ret,
   output logic             irq_valid,
   output logic             irq_hi,
   output logic [VEC_W-1:0] irq_vector,
   output logic             wake_req
);
   if (VEC_W < 7 || VEC_W > 16) begin : g_bad_vec
      $error("intc2l: VEC_W must lie in 7..16");
   end

   localparam int PAD = 16 - VEC_W;

   logic             glb_en;
   logic [3:0]       core_en, core_pri;
   logic [7:0]       port_en, port_pri, port_flag;
   logic [NSRC-1:0]  req_raw, req_en, pri;
   logic             svc_hi, svc_lo;
   logic [SRC_W-1:0] win;
   logic [15:0]      vec_full;
   logic [PAD:0]     vec_unused;

   intc2l_sfr #(
      .SYNC_STAGES(SYNC_STAGES),
      .A_CEN(A_CEN), .A_PEN(A_PEN), .A_CPR(A_CPR),
      .A_PPR(A_PPR), .A_POL(A_POL), .A_FLG(A_FLG)
   ) u_sfr (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (sfr_wr),
      .addr     (sfr_addr),
      .wdata    (sfr_wdata),
      .rdata    (sfr_rdata),
      .port_pin (port_pin),
      .glb_en   (glb_en),
      .core_en  (core_en),
      .port_en  (port_en),
      .core_pri (core_pri),
      .port_pri (port_pri),
      .port_flag(port_flag)
   );

   assign req_raw = {port_flag, tmr_req[1], ext_req[1], tmr_req[0], ext_req[0]};
   assign req_en  = glb_en ? (req_raw & {port_en, core_en}) : '0;
   assign pri     = {port_pri, core_pri};

   intc2l_arb u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .hi_req  (req_en & pri),
      .lo_req  (req_en & ~pri),
      .allow_hi(!svc_hi),
      .allow_lo(!svc_hi && !svc_lo),
      .valid   (irq_valid),
      .hi      (irq_hi),
      .src     (win)
   );

   intc2l_nest u_nest (
      .clk    (clk),
      .rst_n  (rst_n),
      .push   (irq_ack && irq_valid),
      .push_hi(irq_hi),
      .pop    (irq_ret),
      .svc_hi (svc_hi),
      .svc_lo (svc_lo)
   );

   assign vec_full   = vec_of(win);
   assign irq_vector = vec_full[VEC_W-1:0];
   assign vec_unused = {vec_full[15:VEC_W-1]};
   assign wake_req   = |(port_flag & port_en);

   // R9
   hi_blocks_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      svc_hi |-> !irq_valid);

   // R9
   lo_needs_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid && !irq_hi) |-> !svc_lo);

   // R9
   ack_records_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && irq_valid && irq_hi && !irq_ret) |=> svc_hi);

   // R5
   gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !glb_en |-> !irq_valid);
endmodule

// File: tb/sim_intc2l.sv
`timescale 1ns/1ps
module sim_intc2l;
   localparam logic [7:0] A_CEN = 8'hA8, A_PEN = 8'hE8, A_CPR = 8'hB8,
                          A_PPR = 8'hF8, A_POL = 8'hE9, A_FLG = 8'hC0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sfr_wr = 1'b0;
   logic [7:0]  sfr_addr = 8'h00;
   logic [7:0]  sfr_wdata = 8'h00;
   logic [7:0]  sfr_rdata;
   logic [1:0]  ext_req = 2'b00;
   logic [1:0]  tmr_req = 2'b00;
   logic [7:0]  port_pin = 8'hFF;
   logic        irq_ack = 1'b0;
   logic        irq_ret = 1'b0;
   logic        irq_valid, irq_hi, wake_req;
   logic [15:0] irq_vector;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   intc2l u0 (
      .clk(clk), .rst_n(rst_n), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
      .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .ext_req(ext_req),
      .tmr_req(tmr_req), .port_pin(port_pin), .irq_ack(irq_ack),
      .irq_ret(irq_ret), .irq_valid(irq_valid), .irq_hi(irq_hi),
      .irq_vector(irq_vector), .wake_req(wake_req)
   );

   function automatic logic [15:0] exp_vec(input int id);
      case (id)
         0: return 16'h0003;  1: return 16'h000B;  2: return 16'h0013;
         3: return 16'h001B;  4: return 16'h003B;  5: return 16'h0043;
         6: return 16'h004B;  7: return 16'h0053;  8: return 16'h005B;
         9: return 16'h0063;  10: return 16'h006B; default: return 16'h0073;
      endcase
   endfunction

   function automatic int exp_rank(input int r);
      case (r)
         0: return 0;  1: return 7;  2: return 1;  3: return 8;
         4: return 2;  5: return 4;  6: return 9;  7: return 3;
         8: return 5;  9: return 10; 10: return 6; default: return 11;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      sfr_wr = 1'b1; sfr_addr = a; sfr_wdata = d;
      @(posedge clk); #1;
      sfr_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      sfr_addr = a; #1;
      d = sfr_rdata;
   endtask

   task automatic ack();
      @(negedge clk); irq_ack = 1'b1;
      @(posedge clk); #1; irq_ack = 1'b0;
   endtask

   task automatic ret();
      @(negedge clk); irq_ret = 1'b1;
      @(posedge clk); #1; irq_ret = 1'b0;
   endtask

   // drive one source by id; port sources through the flag register
   task automatic set_src(input int id, input logic v, inout logic [7:0] flg);
      case (id)
         0: ext_req[0] = v;
         1: tmr_req[0] = v;
         2: ext_req[1] = v;
         3: tmr_req[1] = v;
         default: begin
            flg[id-4] = v;
            wr(A_FLG, flg);
         end
      endcase
      #1;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      rd(A_CEN, d); chk("R1 core enable", d, 0);
      rd(A_PEN, d); chk("R1 port enable", d, 0);
      rd(A_CPR, d); chk("R1 core prio", d, 0);
      rd(A_PPR, d); chk("R1 port prio", d, 0);
      rd(A_POL, d); chk("R1 polarity", d, 0);
      rd(A_FLG, d); chk("R1 flags", d, 0);
      chk("R1 valid", irq_valid, 0);
      chk("R1 wake", wake_req, 0);
   endtask

   task automatic t_regmap();
      logic [7:0] d;
      wr(A_CEN, 8'hFF); wr(A_PEN, 8'h5A); wr(A_CPR, 8'hFF);
      wr(A_PPR, 8'hA5); wr(A_POL, 8'h3C);
      rd(A_CEN, d); chk("R2 core enable bits", d, 8'h8F);
      rd(A_PEN, d); chk("R2 port enable", d, 8'h5A);
      rd(A_CPR, d); chk("R2 core prio bits", d, 8'h0F);
      rd(A_PPR, d); chk("R2 port prio", d, 8'hA5);
      rd(A_POL, d); chk("R2 polarity", d, 8'h3C);
      rd(8'h00, d); chk("R2 unmapped", d, 8'h00);
      wr(A_POL, 8'h00); wr(A_FLG, 8'h00);
      wr(A_CEN, 8'h00); wr(A_PEN, 8'h00); wr(A_CPR, 8'h00); wr(A_PPR, 8'h00);
      rd(A_FLG, d); chk("R2 flags cleared", d, 8'h00);
   endtask

   task automatic t_sync();
      logic [7:0] d;
      @(negedge clk); port_pin[3] = 1'b0;
      @(posedge clk); @(posedge clk); #1;
      rd(A_FLG, d); chk("R3 flag not yet after two edges", d[3], 0);
      @(posedge clk); #1;
      rd(A_FLG, d); chk("R3 flag after third edge", d[3], 1);
      wr(A_FLG, 8'h00);
      rd(A_FLG, d); chk("R4 write cannot clear active input", d[3], 1);
      @(negedge clk); port_pin[3] = 1'b1;
      repeat (4) @(posedge clk); #1;
      rd(A_FLG, d); chk("R4 flag sticky after release", d[3], 1);
      wr(A_FLG, 8'h00);
      rd(A_FLG, d); chk("R4 software clear", d, 8'h00);
      wr(A_POL, 8'h01);
      rd(A_FLG, d); chk("R3 active-high not yet", d[0], 0);
      @(posedge clk); #1;
      rd(A_FLG, d); chk("R3 active-high polarity", d[0], 1);
      wr(A_POL, 8'h00); wr(A_FLG, 8'h00);
      rd(A_FLG, d); chk("R3 polarity restored", d, 8'h00);
   endtask

   task automatic t_enable();
      ext_req[0] = 1'b1;
      wr(A_CEN, 8'h01);
      chk("R5 global off", irq_valid, 0);
      wr(A_CEN, 8'h80);
      chk("R5 source off", irq_valid, 0);
      wr(A_CEN, 8'h81);
      chk("R5 both on", irq_valid, 1);
      chk("R12 ext0 vector", irq_vector, 16'h0003);
      ext_req[0] = 1'b0; #1;
      chk("R12 level drop", irq_valid, 0);
      wr(A_CEN, 8'h00);
   endtask

   task automatic t_vectors();
      logic [7:0] flg = 8'h00;
      wr(A_CEN, 8'h8F); wr(A_PEN, 8'hFF);
      for (int id = 0; id < 12; id++) begin
         set_src(id, 1'b1, flg);
         chk($sformatf("R6 valid id%0d", id), irq_valid, 1);
         chk($sformatf("R6 vector id%0d", id), irq_vector, exp_vec(id));
         set_src(id, 1'b0, flg);
      end
      chk("R12 all idle", irq_valid, 0);
   endtask

   task automatic t_order();
      logic [7:0] flg = 8'h00;
      for (int id = 0; id < 12; id++) set_src(id, 1'b1, flg);
      wr(A_PPR, 8'h80);
      chk("R8 high level wins", irq_vector, 16'h0073);
      chk("R8 level reported", irq_hi, 1);
      wr(A_PPR, 8'h00);
      for (int r = 0; r < 12; r++) begin
         chk($sformatf("R7 rank %0d", r), irq_vector, exp_vec(exp_rank(r)));
         chk($sformatf("R8 low level rank %0d", r), irq_hi, 0);
         set_src(exp_rank(r), 1'b0, flg);
      end
      chk("R7 none left", irq_valid, 0);
   endtask

   task automatic t_nest();
      ext_req[0] = 1'b1; #1;
      chk("R9 low presented", irq_valid, 1);
      ack();
      chk("R9 low blocks low", irq_valid, 0);
      wr(A_PPR, 8'h01); wr(A_FLG, 8'h01);
      chk("R9 high preempts low", irq_valid, 1);
      chk("R9 preempt vector", irq_vector, 16'h003B);
      ack();
      chk("R9 high blocks all", irq_valid, 0);
      wr(A_PPR, 8'h81); wr(A_FLG, 8'h81);
      chk("R9 high blocks high", irq_valid, 0);
      ret();
      chk("R10 re-entry after return", irq_valid, 1);
      chk("R10 re-entry vector", irq_vector, 16'h003B);
      wr(A_FLG, 8'h00);
      chk("R9 low still in service", irq_valid, 0);
      ret();
      chk("R10 low re-entry", irq_vector, 16'h0003);
      chk("R10 low re-entry valid", irq_valid, 1);
      ext_req[0] = 1'b0;
      wr(A_PPR, 8'h00); wr(A_CEN, 8'h00); wr(A_PEN, 8'h00);
   endtask

   task automatic t_wake();
      wr(A_FLG, 8'h10);
      chk("R11 flag without enable", wake_req, 0);
      wr(A_PEN, 8'h10);
      chk("R11 wake with global off", wake_req, 1);
      chk("R11 no vector with global off", irq_valid, 0);
      wr(A_PEN, 8'h00);
      chk("R11 enable removed", wake_req, 0);
      wr(A_FLG, 8'h00);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;
      t_reset();
      t_regmap();
      t_sync();
      t_enable();
      t_vectors();
      t_order();
      t_nest();
      t_wake();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule